// File: doc/BRIEF.md
# Backup Supply Switchover Controller

This block makes the digital decisions for a supply supervisor that has a backup battery. An ADC front end outside the block delivers millivolt codes for the main supply, the backup battery and a power-fail sense input. The front end raises `sample_valid` for one cycle each time a new set of codes is ready. The block registers its decisions only on those cycles. From each sample it decides which source feeds the protected rail, it flags loss of the sense input, and it decides whether the chip-enable path to protected memory is open.

Each comparison has hysteresis. Source selection uses two margins measured relative to the battery code, so the trip point moves with the battery voltage. The reset-threshold check and the power-fail check use fixed trip levels with a rising offset. The chip-enable path is purely combinational from input to output, and the only registered part is its gate enable. After reset the block assumes the worst case: it selects the battery, reports a power fail and holds chip-enable inactive until samples show good supplies. A build parameter lowers the reset trip level from 4650 mV to 4400 mV for the low-threshold variant.

Top module: `supply_switch_ctrl`

## Requirements
- R1: While `rst_n` is low and after its release with no sample yet, `on_batt` = 1, `pwr_fail_n` = 0 and `ce_out_n` = 1 whatever `ce_in_n` is.
- R2: When the main source is selected, a sample with `main_mv` <= `batt_mv` + 50 selects the battery.
- R3: When the battery is selected, only a sample with `main_mv` > `batt_mv` + 70 selects the main source again. Samples in the band between the two margins keep the current source.
- R4: `on_batt` is 1 exactly while the battery is selected and 0 while the main source is selected.
- R5: `pwr_fail_n` falls to 0 on a sample with `sense_mv` < 1300. After that it returns to 1 only on a sample with `sense_mv` >= 1320.
- R6: A sample with `main_mv` < `batt_mv` forces `pwr_fail_n` to 0 whatever the sense level is. The output stays 0 until a sample with `main_mv` >= `batt_mv` arrives.
- R7: While the gate is enabled, `ce_out_n` equals `ce_in_n` in the same cycle, with no clock in the path.
- R8: A sample with `main_mv` < 4650 disables the gate, and `ce_out_n` is then held at 1. Only a sample with `main_mv` >= 4690 enables it again.
- R9: Input codes present while `sample_valid` is 0 change none of the registered outputs.
- R10: A qualifying sample changes `on_batt` and `pwr_fail_n` on the clock edge that captures it. Before that edge both outputs still show their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sample_valid | input | 1 | One-cycle strobe: the three codes are a new sample |
| main_mv | input | 16 | Main supply level, millivolts |
| batt_mv | input | 16 | Backup battery level, millivolts |
| sense_mv | input | 16 | Power-fail sense level, millivolts |
| ce_in_n | input | 1 | Chip-enable request, active low |
| on_batt | output | 1 | 1 while the battery feeds the protected rail |
| pwr_fail_n | output | 1 | 0 on power-fail or while the main supply is below the battery |
| ce_out_n | output | 1 | Gated chip-enable, active low |

## Verification
On every cycle the assertions check four things: a strobe-free cycle leaves every comparator state unchanged, a sample at or below the falling margin moves the block onto the battery, a sample above the rising margin moves it back to the main source, and a sample under the battery or under the reset level forces the power-fail and chip-enable outputs inactive. Only the bench scenarios can show some other properties. These are that the switch happens at exactly the millivolt step where the trip point lies on slow ramps in both directions, that the band between the margins really holds state, that the sense hysteresis holds, and that the chip-enable path follows its input with no clock delay.

// File: rtl/swo_pkg.sv
package swo_pkg;
  localparam int unsigned MV_W = 16;
  typedef logic [MV_W-1:0] mv_t;
  typedef logic [MV_W:0]   mv_ext_t;

  // Widen a code by one bit so that adding an offset cannot overflow
  function automatic mv_ext_t widen(input mv_t a);
    return {1'b0, a};
  endfunction

  // Code plus a constant margin, in the widened domain
  function automatic mv_ext_t mv_plus(input mv_t a, input int unsigned off);
    return widen(a) + mv_ext_t'(off);
  endfunction
endpackage

// File: rtl/hyst_cmp.sv
module hyst_cmp import swo_pkg::*; #(
  parameter bit RST_STATE = 1'b0
)(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    upd,
  input  mv_ext_t level,
  input  mv_ext_t lo_trip,
  input  mv_ext_t hi_trip,
  output logic    state
);
  logic fall_evt;
  logic rise_evt;

  assign fall_evt = upd &&  state && (level <  lo_trip);
  assign rise_evt = upd && !state && (level >= hi_trip);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        state <= RST_STATE;
    else if (fall_evt) state <= 1'b0;
    else if (rise_evt) state <= 1'b1;
  end

  // R9: with no sample strobe the comparator holds its state
  a_r9_hold_no_sample: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> $stable(state));
endmodule

// File: rtl/ce_gate.sv
module ce_gate (
  input  logic gate_en,
  input  logic ce_in_n,
  output logic ce_out_n
);
  always_comb begin
    if (gate_en) ce_out_n = ce_in_n;
    else         ce_out_n = 1'b1;
  end
endmodule

// File: rtl/supply_switch_ctrl.sv
module supply_switch_ctrl import swo_pkg::*; #(
  parameter int unsigned FALL_MARGIN_MV  = 50,
  parameter int unsigned RISE_MARGIN_MV  = 70,
  parameter int unsigned RST_NOM_MV      = 4650,
  parameter int unsigned RST_LOW_MV      = 4400,
  parameter int unsigned RST_HYST_MV     = 40,
  parameter int unsigned PF_TRIP_MV      = 1300,
  parameter int unsigned PF_HYST_MV      = 20,
  parameter bit          LOW_RST_VARIANT = 1'b0
)(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           sample_valid,
  input  logic [MV_W-1:0] main_mv,
  input  logic [MV_W-1:0] batt_mv,
  input  logic [MV_W-1:0] sense_mv,
  input  logic           ce_in_n,
  output logic           on_batt,
  output logic           pwr_fail_n,
  output logic           ce_out_n
);
  localparam int unsigned RST_TRIP_MV = LOW_RST_VARIANT ? RST_LOW_MV : RST_NOM_MV;
  localparam mv_ext_t RST_LO = mv_ext_t'(RST_TRIP_MV);
  localparam mv_ext_t RST_HI = mv_ext_t'(RST_TRIP_MV + RST_HYST_MV);
  localparam mv_ext_t PF_LO  = mv_ext_t'(PF_TRIP_MV);
  localparam mv_ext_t PF_HI  = mv_ext_t'(PF_TRIP_MV + PF_HYST_MV);

  // Named internal events for checking
  mv_ext_t main_w;
  mv_ext_t src_lo_trip;   // main must reach this to stay on main
  mv_ext_t src_hi_trip;   // main must reach this to return to main
  logic    main_selected;
  logic    gate_en;
  logic    sense_ok;
  logic    below_batt_q;
  logic    below_batt_now;

  assign main_w         = widen(main_mv);
  assign src_lo_trip    = mv_plus(batt_mv, FALL_MARGIN_MV + 1);
  assign src_hi_trip    = mv_plus(batt_mv, RISE_MARGIN_MV + 1);
  assign below_batt_now = main_w < widen(batt_mv);

  hyst_cmp #(.RST_STATE(1'b0)) i_src_cmp (
    .clk(clk), .rst_n(rst_n), .upd(sample_valid), .level(main_w),
    .lo_trip(src_lo_trip), .hi_trip(src_hi_trip), .state(main_selected)
  );

  hyst_cmp #(.RST_STATE(1'b0)) i_rst_cmp (
    .clk(clk), .rst_n(rst_n), .upd(sample_valid), .level(main_w),
    .lo_trip(RST_LO), .hi_trip(RST_HI), .state(gate_en)
  );

  hyst_cmp #(.RST_STATE(1'b0)) i_pf_cmp (
    .clk(clk), .rst_n(rst_n), .upd(sample_valid), .level(widen(sense_mv)),
    .lo_trip(PF_LO), .hi_trip(PF_HI), .state(sense_ok)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            below_batt_q <= 1'b1;
    else if (sample_valid) below_batt_q <= below_batt_now;
  end

  assign on_batt    = ~main_selected;
  assign pwr_fail_n = sense_ok & ~below_batt_q;

  ce_gate i_ce_gate (.gate_en(gate_en), .ce_in_n(ce_in_n), .ce_out_n(ce_out_n));

  // R2: falling margin reached while on main -> battery next cycle
  a_r2_drop_to_batt: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_valid && !on_batt && (main_w <= mv_plus(batt_mv, FALL_MARGIN_MV)))
    |=> on_batt);

  // R3: rising margin exceeded while on battery -> main next cycle
  a_r3_back_to_main: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_valid && on_batt && (main_w > mv_plus(batt_mv, RISE_MARGIN_MV)))
    |=> !on_batt);

  // R6: supply under battery forces the power-fail output low
  a_r6_pf_forced: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_valid && (main_mv < batt_mv)) |=> !pwr_fail_n);

  // R8: supply under reset level forces chip-enable inactive
  a_r8_ce_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_valid && (main_w < RST_LO)) |=> ce_out_n);
endmodule

// File: tb/test_supply_switch_ctrl.sv
module test_supply_switch_ctrl;
  import swo_pkg::*;

  logic clk = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  logic rst_n, sample_valid, ce_in_n;
  logic [MV_W-1:0] main_mv, batt_mv, sense_mv;
  logic on_batt, pwr_fail_n, ce_out_n;

  supply_switch_ctrl i_supply_switch_ctrl (
    .clk(clk), .rst_n(rst_n), .sample_valid(sample_valid),
    .main_mv(main_mv), .batt_mv(batt_mv), .sense_mv(sense_mv),
    .ce_in_n(ce_in_n), .on_batt(on_batt), .pwr_fail_n(pwr_fail_n),
    .ce_out_n(ce_out_n)
  );

  typedef struct packed { logic batt; logic pfn; logic cen; } exp_t;
  exp_t exp_q[$];

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // Reference state, written from the requirements
  bit m_on_main = 0, m_gate = 0, m_sense = 0, m_below = 1;

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic exp_t model_out(input logic ce);
    exp_t e;
    e.batt = !m_on_main;                         // R4
    e.pfn  = m_sense && !m_below;                // R5 R6
    e.cen  = m_gate ? ce : 1'b1;                 // R7 R8
    return e;
  endfunction

  // Driver: one sample, model update, expected item pushed
  task automatic drive(input int mn, input int bt, input int sn, input logic ce);
    exp_t pre;
    @(negedge clk);
    pre = model_out(ce);
    main_mv = mv_t'(mn); batt_mv = mv_t'(bt); sense_mv = mv_t'(sn);
    ce_in_n = ce; sample_valid = 1'b1;
    #5;
    chk("R10", "on_batt before edge", on_batt, pre.batt);
    chk("R10", "pwr_fail_n before edge", pwr_fail_n, pre.pfn);
    if (m_on_main && mn <= bt + 50) m_on_main = 0;        // R2
    else if (!m_on_main && mn > bt + 70) m_on_main = 1;   // R3
    if (m_gate && mn < 4650) m_gate = 0;                  // R8
    else if (!m_gate && mn >= 4690) m_gate = 1;
    if (m_sense && sn < 1300) m_sense = 0;                // R5
    else if (!m_sense && sn >= 1320) m_sense = 1;
    m_below = (mn < bt);                                  // R6
    exp_q.push_back(model_out(ce));
    @(negedge clk);
    sample_valid = 1'b0;
  endtask

  // Monitor: compare after each captured sample
  always @(posedge clk) begin
    if (rst_n && sample_valid) begin
      exp_t e;
      #5;
      if (exp_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL R10 monitor: actual empty queue expected item");
      end else begin
        e = exp_q.pop_front();
        chk("R2 R3 R4", "on_batt", on_batt, e.batt);
        chk("R5 R6", "pwr_fail_n", pwr_fail_n, e.pfn);
        chk("R7 R8", "ce_out_n", ce_out_n, e.cen);
      end
    end
  end

  task automatic ce_poke(input logic v);
    @(negedge clk);
    ce_in_n = v;
    #2;
    chk(m_gate ? "R7" : "R8", "ce_out_n comb", ce_out_n, m_gate ? v : 1'b1);
  endtask

  initial begin
    rst_n = 0; sample_valid = 0; ce_in_n = 0;
    main_mv = '0; batt_mv = '0; sense_mv = '0;
    repeat (3) @(negedge clk);
    chk("R1", "on_batt in reset", on_batt, 1'b1);
    chk("R1", "pwr_fail_n in reset", pwr_fail_n, 1'b0);
    chk("R1", "ce_out_n in reset", ce_out_n, 1'b1);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk("R1", "on_batt after reset", on_batt, 1'b1);
    chk("R1", "ce_out_n after reset", ce_out_n, 1'b1);

    // Slow main ramp up then down against a 3000 mV battery
    for (int v = 2900; v <= 4800; v++) drive(v, 3000, 1500, logic'(v[0]));
    for (int v = 4800; v >= 2900; v--) drive(v, 3000, 1500, logic'(v[0]));

    // Sense ramp with healthy supply
    drive(5000, 3000, 1500, 1'b0);
    for (int s = 1400; s >= 1250; s--) drive(5000, 3000, s, 1'b1);
    for (int s = 1250; s <= 1400; s++) drive(5000, 3000, s, 1'b0);

    // Combinational chip-enable path, gate open then closed
    ce_poke(1'b0); ce_poke(1'b1); ce_poke(1'b0);
    drive(4600, 3000, 1500, 1'b0);
    ce_poke(1'b1); ce_poke(1'b0);
    drive(5000, 3000, 1500, 1'b0);
    ce_poke(1'b1); ce_poke(1'b0);

    // R9: codes without strobe are ignored
    @(negedge clk);
    main_mv = mv_t'(100); batt_mv = mv_t'(4000); sense_mv = mv_t'(10);
    repeat (3) @(negedge clk);
    chk("R9", "on_batt unstrobed", on_batt, 1'b0);
    chk("R9", "pwr_fail_n unstrobed", pwr_fail_n, 1'b1);
    chk("R9", "ce_out_n unstrobed", ce_out_n, 1'b0);

    // High battery: trip points move with the battery code
    for (int v = 4400; v >= 4100; v--) drive(v, 4200, 1500, 1'b0);
    for (int v = 4100; v <= 4400; v++) drive(v, 4200, 1500, 1'b0);

    repeat (4) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #(20 * 190000);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule